// File: doc/BRIEF.md
# Fan Tachometer Period Capture

This block measures the rotation period of up to four fans. It visits the fans one after another. For each fan it counts reference ticks between qualifying edges of that fan's tach signal. The tach inputs first pass through a two-flop synchronizer and an edge detector. The reference tick comes from a parameterized prescaler, so a simulation can use a short measurement window. Each capture ends with a one-cycle done pulse. That pulse comes with a result word: the measured period value in the upper bits and a two-bit quality code in the two lowest bits. A per-fan under-speed flag is raised when the period value is larger than a programmed limit. Because only slow fans are a failure, only an upper limit on the period exists.

The block has two capture modes. Normal mode counts across two full tach periods and always reports quality `00`. Smart mode is for fans driven by a low-side PWM switch, which corrupts the tach signal while the switch is off. At the start of a smart capture the block emits a sync pulse, so that all PWM generators begin their active phase together. It then asks them to keep the drive on for a bounded window while it counts. The window ends early once two periods have been counted. When the window expires, the result falls back to a doubled single-period count or to full scale.

Top module: `fantach_capture`

## Requirements
- R1: While reset is held and in the first cycle after it, `done_o`, `valid_o`, `underspeed_o`, `pwm_hold_o` and `result_o` are all zero.
- R2: Fans are captured in the order 0, 1, ..., NUM_FANS-1 and then wrap. Each capture ends with `done_o` high for exactly one cycle, while `fan_sel_o` names the fan just measured. At that point `valid_o` for that fan is set.
- R3: In normal mode (`smart_i`=0) a fan whose qualifying edges are P ticks apart reports the value 2*P in `result_o[VAL_W+1:2]`, and `result_o[1:0]` reads `00`.
- R4: The period counter saturates at full scale (all ones), so a two-period span above full scale reports all ones. In normal mode, a fan that does not finish two periods within 2^(VAL_W+1) ticks also reports all ones with quality `00`.
- R5: `edge_sel_i` bit 0 enables rising edges and bit 1 enables falling edges, and `00` behaves as rising. When both bits are set, the first edge seen in a capture fixes the edge type, and only that type is counted for the rest of the capture.
- R6: In smart mode, `pwm_sync_o` pulses in the cycle before `pwm_hold_o` rises. `pwm_hold_o` then stays high while the capture runs.
- R7: In smart mode, once a second period completes, the value 2*P is reported with quality `11`, and `pwm_hold_o` is already low in the done cycle.
- R8: In smart mode, if exactly one period completes before the window closes, the value is twice that period count (saturating at full scale) with quality `10`.
- R9: In smart mode, if no complete period is seen within the window, the value is all ones with quality `10`.
- R10: `pwm_hold_o` is never high for more than WIN_TICKS ticks in one capture. With no early finish it stays high for exactly WIN_TICKS ticks.
- R11: At every done, `underspeed_o` for the measured fan is set exactly when the reported value is greater than `limit_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smart_i | input | 1 | 1 selects smart mode for captures that start after this |
| edge_sel_i | input | 2 | Edge enables: bit 0 rising, bit 1 falling |
| limit_i | input | VAL_W | Under-speed period limit |
| tach_i | input | NUM_FANS | Raw tach signals, one per fan |
| pwm_sync_o | output | 1 | Pulse that aligns PWM active phases at smart capture start |
| pwm_hold_o | output | 1 | Keep PWM drive active while high |
| fan_sel_o | output | FAN_W | Fan currently being captured |
| done_o | output | 1 | One-cycle capture-complete pulse |
| result_o | output | VAL_W+2 | Period value over a two-bit quality code |
| valid_o | output | NUM_FANS | Per-fan flag: at least one capture finished |
| underspeed_o | output | NUM_FANS | Per-fan flag: last value above the limit |

## Verification
The hardest case to reach from the ports is a smart capture with exactly one complete period inside the window. A free-running tach signal almost never gives that, because its phase relative to the capture start is arbitrary. The bench therefore watches `pwm_sync_o` together with `fan_sel_o`, and for each fan it plays a scripted burst of edges at fixed offsets from the start of that fan's capture. This gives zero, one or two periods on demand. The same scripted bursts show whether a both-edges setting locks onto one edge type: two-cycle-wide pulses would give a tiny period if both edge types were counted.

// File: rtl/fantach_pkg.sv
package fantach_pkg;
   typedef enum logic [1:0] {
      ST_START = 2'd0,
      ST_ARM   = 2'd1,
      ST_COUNT = 2'd2,
      ST_FIN   = 2'd3
   } cap_state_e;

   localparam logic [1:0] QUAL_NORMAL = 2'b00;
   localparam logic [1:0] QUAL_ONE    = 2'b10;
   localparam logic [1:0] QUAL_TWO    = 2'b11;
endpackage

// File: rtl/fantach_tick.sv
module fantach_tick #(
   parameter int unsigned TICK_DIV = 64
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick_o
);
   generate
      if (TICK_DIV < 1) begin : g_bad_div
         $error("fantach_tick: TICK_DIV must be at least 1");
      end
      if (TICK_DIV == 1) begin : g_pass
         assign tick_o = 1'b1;
      end else begin : g_div
         localparam int unsigned DW = $clog2(TICK_DIV);
         localparam logic [DW-1:0] LAST = DW'(TICK_DIV - 1);
         logic [DW-1:0] div_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)             div_q <= '0;
            else if (div_q == LAST) div_q <= '0;
            else                    div_q <= div_q + 1'b1;
         end
         assign tick_o = (div_q == LAST);
      end
   endgenerate
endmodule

// File: rtl/fantach_edge.sv
module fantach_edge #(
   parameter int unsigned NUM_FANS = 4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_FANS-1:0] tach_i,
   output logic [NUM_FANS-1:0] rise_o,
   output logic [NUM_FANS-1:0] fall_o
);
   generate
      for (genvar g = 0; g < NUM_FANS; g++) begin : g_fan
         logic [2:0] sh_q;   // [0],[1] synchronizer, [2] previous sample
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sh_q <= '0;
            else        sh_q <= {sh_q[1:0], tach_i[g]};
         end
         assign rise_o[g] =  sh_q[1] & ~sh_q[2];
         assign fall_o[g] = ~sh_q[1] &  sh_q[2];
      end
   endgenerate
endmodule

// File: rtl/fantach_encode.sv
module fantach_encode
   import fantach_pkg::*;
#(
   parameter int unsigned VAL_W = 10
) (
   input  logic             smart_i,
   input  logic             two_i,
   input  logic             one_seen_i,
   input  logic [VAL_W-1:0] cnt_i,
   input  logic [VAL_W-1:0] one_cnt_i,
   output logic [VAL_W-1:0] val_o,
   output logic [1:0]       qual_o
);
   logic [VAL_W:0] dbl;
   assign dbl = {one_cnt_i, 1'b0};

   always_comb begin
      if (two_i) begin
         val_o  = cnt_i;
         qual_o = smart_i ? QUAL_TWO : QUAL_NORMAL;
      end else if (smart_i && one_seen_i) begin
         val_o  = dbl[VAL_W] ? '1 : dbl[VAL_W-1:0];
         qual_o = QUAL_ONE;
      end else begin
         val_o  = '1;
         qual_o = smart_i ? QUAL_ONE : QUAL_NORMAL;
      end
   end
endmodule

// File: rtl/fantach_capture.sv
module fantach_capture
   import fantach_pkg::*;
#(
   parameter int unsigned NUM_FANS  = 4,
   parameter int unsigned VAL_W     = 10,
   parameter int unsigned TICK_DIV  = 64,
   parameter int unsigned WIN_TICKS = 1125,
   localparam int unsigned FAN_W    = (NUM_FANS > 1) ? $clog2(NUM_FANS) : 1,
   localparam int unsigned RES_W    = VAL_W + 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                smart_i,
   input  logic [1:0]          edge_sel_i,
   input  logic [VAL_W-1:0]    limit_i,
   input  logic [NUM_FANS-1:0] tach_i,
   output logic                pwm_sync_o,
   output logic                pwm_hold_o,
   output logic [FAN_W-1:0]    fan_sel_o,
   output logic                done_o,
   output logic [RES_W-1:0]    result_o,
   output logic [NUM_FANS-1:0] valid_o,
   output logic [NUM_FANS-1:0] underspeed_o
);
   localparam int unsigned NORM_TICKS = 2 ** (VAL_W + 1);
   localparam int unsigned TMR_W      = $clog2(NORM_TICKS + WIN_TICKS + 1);
   localparam int unsigned HOLD_CYC   = WIN_TICKS * TICK_DIV;
   localparam int unsigned HL_W       = $clog2(HOLD_CYC + 2);
   localparam logic [TMR_W-1:0] WIN_LIM  = TMR_W'(WIN_TICKS - 1);
   localparam logic [TMR_W-1:0] NORM_LIM = TMR_W'(NORM_TICKS - 1);
   localparam logic [FAN_W-1:0] LAST_FAN = FAN_W'(NUM_FANS - 1);

   generate
      if (NUM_FANS < 1)  begin : g_bad_fans $error("fantach_capture: NUM_FANS < 1"); end
      if (VAL_W < 4)     begin : g_bad_w    $error("fantach_capture: VAL_W < 4"); end
      if (WIN_TICKS < 2) begin : g_bad_win  $error("fantach_capture: WIN_TICKS < 2"); end
   endgenerate

   logic                tick;
   logic [NUM_FANS-1:0] rise, fall;

   fantach_tick #(.TICK_DIV(TICK_DIV)) u_tick (
      .clk(clk), .rst_n(rst_n), .tick_o(tick));

   fantach_edge #(.NUM_FANS(NUM_FANS)) u_edge (
      .clk(clk), .rst_n(rst_n), .tach_i(tach_i), .rise_o(rise), .fall_o(fall));

   cap_state_e          state_q;
   logic [FAN_W-1:0]    sel_q;
   logic                smart_q, lock_fall_q, have_one_q;
   logic [VAL_W-1:0]    cnt_q, one_q, cnt_nx;
   logic [TMR_W-1:0]    tmr_q;
   logic [RES_W-1:0]    result_q;
   logic [NUM_FANS-1:0] valid_q, under_q;

   logic sel_rise, sel_fall, rise_en, fall_en, arm_hit, cnt_edge;
   logic timeout, two_now, finish;
   logic [VAL_W-1:0] enc_val;
   logic [1:0]       enc_qual;

   assign sel_rise = rise[sel_q];
   assign sel_fall = fall[sel_q];
   assign rise_en  = edge_sel_i[0] | ~edge_sel_i[1];
   assign fall_en  = edge_sel_i[1];
   assign arm_hit  = (sel_rise & rise_en) | (sel_fall & fall_en);
   assign cnt_edge = lock_fall_q ? sel_fall : sel_rise;
   assign cnt_nx   = (tick && cnt_q != '1) ? cnt_q + 1'b1 : cnt_q;
   assign timeout  = tick && (tmr_q == (smart_q ? WIN_LIM : NORM_LIM));
   assign two_now  = (state_q == ST_COUNT) && cnt_edge && have_one_q;
   assign finish   = ((state_q == ST_ARM) || (state_q == ST_COUNT)) && (timeout || two_now);

   fantach_encode #(.VAL_W(VAL_W)) u_enc (
      .smart_i(smart_q), .two_i(two_now), .one_seen_i(have_one_q),
      .cnt_i(cnt_nx), .one_cnt_i(one_q), .val_o(enc_val), .qual_o(enc_qual));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q     <= ST_START;
         sel_q       <= '0;
         smart_q     <= 1'b0;
         lock_fall_q <= 1'b0;
         have_one_q  <= 1'b0;
         cnt_q       <= '0;
         one_q       <= '0;
         tmr_q       <= '0;
         result_q    <= '0;
         valid_q     <= '0;
         under_q     <= '0;
      end else begin
         case (state_q)
            ST_START: begin
               smart_q    <= smart_i;
               tmr_q      <= '0;
               cnt_q      <= '0;
               one_q      <= '0;
               have_one_q <= 1'b0;
               state_q    <= ST_ARM;
            end
            ST_ARM, ST_COUNT: begin
               if (tick) tmr_q <= tmr_q + 1'b1;
               if (state_q == ST_COUNT) begin
                  cnt_q <= cnt_nx;
                  if (cnt_edge && !have_one_q) begin
                     have_one_q <= 1'b1;
                     one_q      <= cnt_nx;
                  end
               end
               if (finish) begin
                  state_q        <= ST_FIN;
                  result_q       <= {enc_val, enc_qual};
                  valid_q[sel_q] <= 1'b1;
                  under_q[sel_q] <= (enc_val > limit_i);
               end else if (state_q == ST_ARM && arm_hit) begin
                  lock_fall_q <= ~(sel_rise & rise_en);
                  cnt_q       <= '0;
                  state_q     <= ST_COUNT;
               end
            end
            default: begin
               sel_q   <= (sel_q == LAST_FAN) ? '0 : sel_q + 1'b1;
               state_q <= ST_START;
            end
         endcase
      end
   end

   assign pwm_sync_o   = (state_q == ST_START) && smart_i;
   assign pwm_hold_o   = smart_q && ((state_q == ST_ARM) || (state_q == ST_COUNT));
   assign done_o       = (state_q == ST_FIN);
   assign fan_sel_o    = sel_q;
   assign result_o     = result_q;
   assign valid_o      = valid_q;
   assign underspeed_o = under_q;

   // Window monitor: cycles the hold output has been high so far.
   logic [HL_W-1:0] hold_len_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                           hold_len_q <= '0;
      else if (!pwm_hold_o)                 hold_len_q <= '0;
      else if (hold_len_q != '1)            hold_len_q <= hold_len_q + 1'b1;
   end

   a_r10_window_bound: assert property (@(posedge clk) disable iff (!rst_n)
      pwm_hold_o |-> (hold_len_q < HL_W'(HOLD_CYC)));

   a_r3_normal_qual: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && !smart_q) |-> (result_o[1:0] == QUAL_NORMAL));

   a_r6_sync_then_hold: assert property (@(posedge clk) disable iff (!rst_n)
      pwm_sync_o |=> pwm_hold_o);

   a_r7_hold_release: assert property (@(posedge clk) disable iff (!rst_n)
      (two_now && smart_q) |=> (!pwm_hold_o && done_o && result_o[1:0] == QUAL_TWO));

   a_r4_cnt_saturate: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_COUNT && cnt_q == '1 && !finish) |=> (cnt_q == '1));

   a_r2_valid_on_done: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (valid_o[fan_sel_o] && $countones(valid_o) >= 1));

   a_r9_smart_qual: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && smart_q) |-> result_o[1]);
endmodule

// File: tb/fantach_capture_tb.sv
`timescale 1ns/1ps
module fantach_capture_tb;
   localparam int N   = 4;
   localparam int VW  = 10;
   localparam int WIN = 300;
   localparam int MAXV = (1 << VW) - 1;

   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic           rst_n;
   logic           smart;
   logic [1:0]     edge_sel;
   logic [VW-1:0]  limit;
   logic [N-1:0]   tach;
   logic           pwm_sync_o, pwm_hold_o, done_o;
   logic [1:0]     fan_sel_o;
   logic [VW+1:0]  result_o;
   logic [N-1:0]   valid_o, underspeed_o;

   fantach_capture #(.NUM_FANS(N), .VAL_W(VW), .TICK_DIV(1), .WIN_TICKS(WIN)) u_dut (
      .clk(clk), .rst_n(rst_n), .smart_i(smart), .edge_sel_i(edge_sel),
      .limit_i(limit), .tach_i(tach), .pwm_sync_o(pwm_sync_o),
      .pwm_hold_o(pwm_hold_o), .fan_sel_o(fan_sel_o), .done_o(done_o),
      .result_o(result_o), .valid_o(valid_o), .underspeed_o(underspeed_o));

   int total = 0;
   int bad   = 0;
   int per[N];
   int s_edges[N];
   int s_gap[N];
   bit smart_ph = 1'b0;

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // free-running square waves for normal mode
   task automatic run_fan(input int f);
      forever begin
         if (smart_ph || per[f] == 0) @(posedge clk);
         else begin
            repeat (per[f] / 2) @(posedge clk);
            #1 if (!smart_ph) tach[f] = 1'b1;
            repeat (per[f] - per[f] / 2) @(posedge clk);
            #1 if (!smart_ph) tach[f] = 1'b0;
         end
      end
   endtask

   initial begin
      for (int i = 0; i < N; i++) begin
         automatic int f = i;
         fork run_fan(f); join_none
      end
   end

   // scripted bursts relative to the start of each smart capture
   initial begin
      forever begin
         @(negedge clk);
         if (smart_ph && pwm_sync_o) begin
            automatic int f = fan_sel_o;
            repeat (10) @(posedge clk);
            for (int e = 0; e < s_edges[f]; e++) begin
               #1 tach[f] = 1'b1;
               repeat (2) @(posedge clk);
               #1 tach[f] = 1'b0;
               if (e != s_edges[f] - 1) repeat (s_gap[f] - 2) @(posedge clk);
            end
         end
      end
   end

   function automatic int norm_exp(input int p);
      if (p == 0 || 2 * p > MAXV) return MAXV;
      return 2 * p;
   endfunction

   function automatic int smart_val(input int e, input int g);
      if (e >= 3) return (2 * g > MAXV) ? MAXV : 2 * g;
      if (e == 2) return (2 * g > MAXV) ? MAXV : 2 * g;
      return MAXV;
   endfunction

   task automatic wait_done();
      do @(negedge clk); while (!done_o);
   endtask

   // R2: consecutive captures visit fans in order
   task automatic settle();
      int prev = -1;
      repeat (N + 1) begin
         wait_done();
         if (prev >= 0)
            chk(int'(fan_sel_o) == (prev + 1) % N, "R2 order", fan_sel_o, (prev + 1) % N);
         chk(valid_o[fan_sel_o] == 1'b1, "R2 valid", valid_o[fan_sel_o], 1);
         prev = fan_sel_o;
      end
   endtask

   task automatic normal_round(input string tag);
      for (int f = 0; f < N; f++) begin
         int ev;
         do wait_done(); while (int'(fan_sel_o) != f);
         ev = norm_exp(per[f]);
         chk(int'(result_o[VW+1:2]) == ev, {tag, " R3/R4 value"}, result_o[VW+1:2], ev);
         chk(result_o[1:0] == 2'b00, {tag, " R3 quality"}, result_o[1:0], 0);
         chk(underspeed_o[f] == (ev > int'(limit)), {tag, " R11 underspeed"},
             underspeed_o[f], ev > int'(limit));
         chk(pwm_hold_o == 1'b0, {tag, " R3 no hold"}, pwm_hold_o, 0);
      end
   endtask

   task automatic smart_round(input string tag);
      for (int f = 0; f < N; f++) begin
         int hc;
         int ev;
         int eq;
         do @(negedge clk); while (!(pwm_sync_o && int'(fan_sel_o) == f));
         @(negedge clk);
         chk(pwm_hold_o == 1'b1, {tag, " R6 hold after sync"}, pwm_hold_o, 1);
         hc = 1;
         do begin
            @(negedge clk);
            if (pwm_hold_o) hc++;
         end while (!done_o);
         ev = smart_val(s_edges[f], s_gap[f]);
         eq = (s_edges[f] >= 3) ? 3 : 2;
         chk(int'(result_o[VW+1:2]) == ev, {tag, " R7/R8/R9 value"}, result_o[VW+1:2], ev);
         chk(int'(result_o[1:0]) == eq, {tag, " R7/R8/R9 quality"}, result_o[1:0], eq);
         chk(pwm_hold_o == 1'b0, {tag, " R7 hold low at done"}, pwm_hold_o, 0);
         if (s_edges[f] >= 3)
            chk(hc < 150, {tag, " R7 early release"}, hc, 150);
         else
            chk(hc == WIN, {tag, " R10 full window"}, hc, WIN);
         chk(underspeed_o[f] == (ev > int'(limit)), {tag, " R11 underspeed"},
             underspeed_o[f], ev > int'(limit));
      end
   endtask

   // watchdog
   initial begin
      repeat (150000) @(posedge clk);
      bad++;
      total++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      rst_n = 1'b0;
      smart = 1'b0;
      edge_sel = 2'b01;
      limit = VW'(150);
      tach = '0;
      per[0] = 20; per[1] = 37; per[2] = 76; per[3] = 600;
      s_edges[0] = 3; s_gap[0] = 50;
      s_edges[1] = 2; s_gap[1] = 80;
      s_edges[2] = 1; s_gap[2] = 40;
      s_edges[3] = 0; s_gap[3] = 40;

      repeat (5) @(negedge clk);
      // R1 reset state
      chk(done_o == 1'b0, "R1 done", done_o, 0);
      chk(valid_o == '0, "R1 valid", valid_o, 0);
      chk(underspeed_o == '0, "R1 underspeed", underspeed_o, 0);
      chk(pwm_hold_o == 1'b0, "R1 hold", pwm_hold_o, 0);
      chk(result_o == '0, "R1 result", result_o, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(done_o == 1'b0 && result_o == '0, "R1 after release", done_o, 0);

      // normal mode, rising edges, includes a saturating slow fan (R4)
      settle();
      normal_round("norm-rise");

      // R5: both edges must lock to one type, giving the same full period
      edge_sel = 2'b11;
      settle();
      normal_round("norm-both R5");

      // R5: 00 behaves as rising
      edge_sel = 2'b00;
      settle();
      normal_round("norm-00 R5");

      // R4: dead fan times out at full scale
      edge_sel = 2'b01;
      per[3] = 0;
      tach[3] = 1'b0;
      settle();
      normal_round("norm-dead R4");

      // smart mode, scripted bursts
      smart = 1'b1;
      smart_ph = 1'b1;
      tach = '0;
      settle();
      smart_round("smart-rise");

      edge_sel = 2'b11;
      settle();
      smart_round("smart-both R5");

      edge_sel = 2'b10;
      settle();
      smart_round("smart-fall R5");

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule